// File: doc/BRIEF.md
# Serial Block-Write Configuration Slave

This block is the write-only control port of a clock-generator configuration bank. A fast system clock samples the two-wire serial bus lines, SCL and SDA. Both lines pass through a synchronizer, and the block then finds START and STOP conditions and SCL edges. Once the block is addressed for a write, it acknowledges two header bytes and ignores what they contain. Every byte after the headers goes into the next register of a six-entry bank, starting from entry 0.

Each register drives configuration fields straight into the clock generator. Entry 0 holds a frequency-select field in bits 6..4. It also holds a spread-spectrum disable in bit 3, where 1 turns spreading off. Bit 0 of entry 0 picks the source of the frequency select: 0 means the external pins and 1 means the stored field. Entry 1 holds eight output enables and entry 2 holds six output enables in bits 5..0. In both, 1 means enabled. Entry 5 holds an 8-bit divider value with its MSB in bit 7. Each entry has its own one-cycle write strobe.

Top module: `cfgs_serial_slave`

## Requirements
- R1: After reset the bank reads 0x06, 0xFF, 0x3F, 0x20, 0x00, 0x00 for entries 0..5. `sda_oe` and every strobe are low.
- R2: A first byte of 0xD2 after START is acknowledged. This byte is the 7-bit address 1101001 followed by write bit 0. Acknowledging means `sda_oe` is high while SCL is high on the ninth clock.
- R3: A first byte whose upper seven bits differ from the device address is not acknowledged. The block stays silent until the next START and no entry changes.
- R4: A first byte holding the device address with bit 0 set (read) is not acknowledged and changes no entry.
- R5: The two bytes after an accepted address are acknowledged. Their values have no effect: the first data byte always lands in entry 0.
- R6: Data bytes are stored in entries 0, 1, 2, ... in arrival order, and each one is acknowledged. Every stored byte raises exactly one one-cycle strobe, on the bit of the entry it went to.
- R7: Reserved bits always read as 0, whatever value was written. These are bit 7 of entry 0, bits 7..6 of entry 2, bits 4, 3, 1 and 0 of entry 3, and all of entry 4.
- R8: Data bytes beyond entry 5 are acknowledged and change nothing.
- R9: A STOP ends the transfer. Entries already written keep their new values, and the next transfer starts again at entry 0.
- R10: A repeated START at any point restarts the address phase. The data that follows it lands again from entry 0.
- R11: `sda_oe` rises only on an SCL falling edge after the eighth bit. It is released after the falling edge that ends the ninth clock, before the next data bit is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain acknowledge) |
| regs_o | output | NREG*8 | Bank contents, entry k in bits 8k+7..8k |
| wr_stb_o | output | NREG | One-cycle pulse per entry when it is written |

## Verification
The bench drives full block writes with varied header values and data patterns. These include all-ones and alternating bytes, which show whether the reserved-bit masking and the entry ordering are correct. A wrong address and a read bit are sent to tell the acknowledge decision apart from the data path. Over-long writes, a STOP after two bytes and a repeated START in the middle of a transfer separate the pointer saturation, the reset of the pointer at STOP and the restart at START. A model in the bench tracks the expected bank contents across all of these.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_CNT, PH_DATA} phase_e;
  typedef enum logic [2:0] {RX_IDLE, RX_BITS, RX_ACK_SET, RX_ACK_HOLD, RX_ACK_END} rx_e;

  // Value an entry takes at reset.
  function automatic byte_t power_up_value(input int idx);
    case (idx)
      0: return 8'h06;
      1: return 8'hFF;
      2: return 8'h3F;
      3: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  // Bits of an entry that keep written data; the others are stuck at 0.
  function automatic byte_t writable_bits(input int idx);
    case (idx)
      0: return 8'h7F;
      2: return 8'h3F;
      3: return 8'hE4;
      4: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic addr_hit(input byte_t b, input logic [6:0] dev);
    return (b[7:1] == dev) && !b[0];
  endfunction
endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // STAGES synchronizer flops plus one history flop per line.
  logic [STAGES:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now = scl_p[STAGES-1];
  assign scl_old = scl_p[STAGES];
  assign sda_s   = sda_p[STAGES-1];
  assign sda_old = sda_p[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/cfgs_byte_rx.sv
module cfgs_byte_rx import cfgs_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scl_rise,
  input  logic  scl_fall,
  input  logic  sda_s,
  input  logic  start_det,
  input  logic  stop_det,
  input  logic  ack_ok,
  output logic  byte_done,
  output byte_t byte_val,
  output logic  sda_oe
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  rx_e st;
  logic [CW-1:0] cnt;
  logic [BYTE_W-2:0] sh;

  assign byte_val  = {sh, sda_s};
  assign byte_done = (st == RX_BITS) && scl_rise && (cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      sh     <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= RX_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= RX_BITS;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        RX_BITS: if (scl_rise) begin
          sh <= byte_val[BYTE_W-2:0];
          if (cnt == LAST_BIT) begin
            cnt <= '0;
            st  <= ack_ok ? RX_ACK_SET : RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_ACK_SET: if (scl_fall) begin
          sda_oe <= 1'b1;
          st     <= RX_ACK_HOLD;
        end
        RX_ACK_HOLD: if (scl_rise) st <= RX_ACK_END;
        RX_ACK_END: if (scl_fall) begin
          sda_oe <= 1'b0;
          st     <= RX_BITS;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgs_reg_bank.sv
module cfgs_reg_bank import cfgs_pkg::*; #(
  parameter int NREG = 6,
  parameter int IW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  byte_t              wr_data,
  output logic [NREG*BYTE_W-1:0] regs_o,
  output logic [NREG-1:0]    wr_stb_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_entry
    localparam logic [IW-1:0] MY_IDX = IW'(i);
    localparam byte_t RST_V  = power_up_value(i);
    localparam byte_t KEEP_M = writable_bits(i);
    logic hit;
    assign hit = wr_en && (wr_idx == MY_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_o[i*BYTE_W +: BYTE_W] <= RST_V;
        wr_stb_o[i]                <= 1'b0;
      end else begin
        wr_stb_o[i] <= hit;
        if (hit) regs_o[i*BYTE_W +: BYTE_W] <= wr_data & KEEP_M;
      end
    end
  end
endmodule

// File: rtl/cfgs_serial_slave.sv
module cfgs_serial_slave import cfgs_pkg::*; #(
  parameter int         NREG        = 6,
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [NREG*BYTE_W-1:0] regs_o,
  output logic [NREG-1:0]        wr_stb_o
);
  localparam int PW = $clog2(NREG + 1);
  localparam logic [PW-1:0] PTR_END = PW'(NREG);

  // Named internal events, observed by the bound checker.
  logic  sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic  byte_done, ack_ok, wr_en;
  byte_t byte_val;
  phase_e phase;
  logic [PW-1:0] ptr;

  cfgs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgs_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .ack_ok(ack_ok), .byte_done(byte_done), .byte_val(byte_val),
    .sda_oe(sda_oe)
  );

  assign ack_ok = (phase != PH_ADDR) || addr_hit(byte_val, DEV_ADDR);
  assign wr_en  = byte_done && (phase == PH_DATA) && (ptr < PTR_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_ADDR;
      ptr   <= '0;
    end else if (start_det || stop_det) begin
      phase <= PH_ADDR;
      ptr   <= '0;
    end else if (byte_done) begin
      case (phase)
        PH_ADDR: if (ack_ok) phase <= PH_CMD;
        PH_CMD:  phase <= PH_CNT;
        PH_CNT:  phase <= PH_DATA;
        default: if (ptr < PTR_END) ptr <= ptr + 1'b1;
      endcase
    end
  end

  cfgs_reg_bank #(.NREG(NREG), .IW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr),
    .wr_data(byte_val), .regs_o(regs_o), .wr_stb_o(wr_stb_o)
  );
endmodule

// File: rtl/cfgs_serial_slave_chk.sv
module cfgs_serial_slave_chk import cfgs_pkg::*; #(
  parameter int NREG = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_fall,
  input logic                   start_det,
  input logic                   stop_det,
  input logic                   byte_done,
  input logic                   sda_oe,
  input logic [NREG*BYTE_W-1:0] regs_o,
  input logic [NREG-1:0]        wr_stb_o
);
  // R11
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R11
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb_o));

  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb_o) |-> $past(byte_done));

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_done) |-> $stable(regs_o));

  for (genvar i = 0; i < NREG; i++) begin : g_rsv
    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (regs_o[i*BYTE_W +: BYTE_W] & ~writable_bits(i)) == '0);
  end
endmodule

bind cfgs_serial_slave cfgs_serial_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .byte_done(byte_done), .sda_oe(sda_oe),
  .regs_o(regs_o), .wr_stb_o(wr_stb_o)
);

// File: tb/cfgs_serial_slave_test.sv
module cfgs_serial_slave_test;
  localparam int NR = 6;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, tb_sda = 1'b1;
  logic sda_oe, line;
  logic [NR*8-1:0] regs;
  logic [NR-1:0] stb;

  always #2.5 clk = ~clk;
  assign line = tb_sda & ~sda_oe;

  cfgs_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .sda_oe(sda_oe), .regs_o(regs), .wr_stb_o(stb)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [NR];
  int stb_cnt [NR];

  always @(negedge clk)
    if (rst_n)
      for (int i = 0; i < NR; i++) if (stb[i]) stb_cnt[i]++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_reset_val(input int k);
    logic [7:0] t [NR] = '{8'h06, 8'hFF, 8'h3F, 8'h20, 8'h00, 8'h00};
    return t[k];
  endfunction

  // Reserved positions cleared one by one, restated from R7.
  function automatic logic [7:0] tb_store(input int k, input logic [7:0] v);
    logic [7:0] r = v;
    if (k == 0) r[7] = 1'b0;
    if (k == 2) r[7:6] = 2'b00;
    if (k == 3) begin r[4] = 0; r[3] = 0; r[1] = 0; r[0] = 0; end
    if (k == 4) r = 8'h00;
    return r;
  endfunction

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    tb_sda = 1'b1; wait_q(1); scl = 1'b1; wait_q(1);
    tb_sda = 1'b0; wait_q(1); scl = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop;
    tb_sda = 1'b0; wait_q(1); scl = 1'b1; wait_q(1);
    tb_sda = 1'b1; wait_q(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tb_sda = b[i]; wait_q(1); scl = 1'b1; wait_q(2); scl = 1'b0; wait_q(1);
    end
    tb_sda = 1'b1; wait_q(1); scl = 1'b1; wait_q(1);
    ack = (line == 1'b0);
    wait_q(1); scl = 1'b0; wait_q(1);
  endtask

  // START, address, two header bytes, n data bytes; model tracks stores.
  task automatic frame(input logic [7:0] a, c, k, input logic [7:0] d [8],
                       input int n, output bit [10:0] acks);
    bit ak;
    acks = '0;
    bus_start;
    send_byte(a, ak); acks[0] = ak;
    send_byte(c, ak); acks[1] = ak;
    send_byte(k, ak); acks[2] = ak;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ak); acks[3+i] = ak;
    end
  endtask

  task automatic model_store(input logic [7:0] d [8], input int n);
    for (int i = 0; i < n && i < NR; i++) model[i] = tb_store(i, d[i]);
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NR; i++)
      check(regs[i*8 +: 8] == model[i], req, regs[i*8 +: 8], model[i]);
  endtask

  task automatic clear_stb;
    for (int i = 0; i < NR; i++) stb_cnt[i] = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NR; i++) model[i] = tb_reset_val(i);
    check_bank("R1 power-up value");
    check(sda_oe == 1'b0, "R1 sda_oe idle", sda_oe, 0);
    check(stb == '0, "R1 strobes idle", stb, 0);
  endtask

  task automatic t_full_write;
    logic [7:0] d [8] = '{8'hAA, 8'h55, 8'hF0, 8'hFF, 8'hFF, 8'h81, 0, 0};
    bit [10:0] a;
    clear_stb;
    frame(8'hD2, 8'hA5, 8'h3C, d, 6, a);
    check(sda_oe == 1'b0, "R11 released before next bit", sda_oe, 0);
    bus_stop;
    check(a[0], "R2 address ack", a[0], 1);
    check(a[2:1] == 2'b11, "R5 header acks", a[2:1], 3);
    check(a[8:3] == 6'h3F, "R6 data acks", a[8:3], 6'h3F);
    model_store(d, 6);
    check_bank("R6 R7 stored values");
    for (int i = 0; i < NR; i++)
      check(stb_cnt[i] == 1, "R6 one strobe per entry", stb_cnt[i], 1);
  endtask

  task automatic t_overflow;
    logic [7:0] d [8] = '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h77, 8'h88};
    bit [10:0] a;
    clear_stb;
    frame(8'hD2, 8'h00, 8'h06, d, 8, a);
    bus_stop;
    check(a[10:9] == 2'b11, "R8 extra bytes acked", a[10:9], 3);
    model_store(d, 6);
    check_bank("R8 extra bytes discarded");
    check(stb_cnt[5] == 1, "R8 no extra strobe", stb_cnt[5], 1);
  endtask

  task automatic t_bad_addr(input logic [7:0] adr, input string req);
    logic [7:0] d [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0};
    bit [10:0] a;
    clear_stb;
    frame(adr, 8'h00, 8'h00, d, 3, a);
    bus_stop;
    check(a == '0, {req, " no ack"}, a, 0);
    check_bank({req, " bank unchanged"});
    check(stb_cnt[0] == 0, {req, " no strobe"}, stb_cnt[0], 0);
  endtask

  task automatic t_stop_mid;
    logic [7:0] d [8] = '{8'h01, 8'h02, 0, 0, 0, 0, 0, 0};
    logic [7:0] e [8] = '{8'h03, 0, 0, 0, 0, 0, 0, 0};
    bit [10:0] a;
    frame(8'hD2, 8'hFF, 8'hFF, d, 2, a);
    bus_stop;
    model_store(d, 2);
    check_bank("R9 partial write kept");
    frame(8'hD2, 8'h04, 8'h01, e, 1, a);
    bus_stop;
    model_store(e, 1);
    check_bank("R9 R5 next write from entry 0");
  endtask

  task automatic t_restart;
    logic [7:0] d [8] = '{8'h44, 8'h66, 0, 0, 0, 0, 0, 0};
    logic [7:0] e [8] = '{8'h05, 0, 0, 0, 0, 0, 0, 0};
    bit [10:0] a;
    frame(8'hD2, 8'h02, 8'h02, d, 2, a);
    model_store(d, 2);
    frame(8'hD2, 8'h03, 8'h09, e, 1, a);
    bus_stop;
    check(a[3:0] == 4'hF, "R10 acks after repeated start", a[3:0], 4'hF);
    model_store(e, 1);
    check_bank("R10 restart lands in entry 0");
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_full_write;
    t_overflow;
    t_bad_addr(8'hA0, "R3");
    t_bad_addr(8'hD3, "R4");
    t_stop_mid;
    t_restart;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule